// File: doc/BRIEF.md
# Command Ring Packet Parser

This block walks a circular ring of 32-bit command words held in its own small memory. A host fills the memory through a write port and then moves a write pointer forward. The parser's read pointer chases that write pointer. Each header word is split into one of three kinds: a full packet, a one-word filler, or an illegal word. A full packet is offered to a downstream handler with its opcode, its total length in words, the raw header and the word that follows the header. The offer is held until the handler takes it. Once it is taken, the read pointer moves past the whole packet.

The control is a five-state machine:
- `S_IDLE` is the wait state. From there the parser either wraps the pointer or starts a fetch (transition *fetch*).
- `S_RD_HDR` classifies the header word. A full packet leads to *capture*, a filler to *skip*, an illegal word to *fault*.
- `S_RD_PAY` latches the word after the header (transition *present*).
- `S_OFFER` holds the packet until the handler accepts it (transition *retire*).
- `S_ERROR` is absorbing until reset.

A packet whose opcode equals `IND_OPCODE` marks a switch to another buffer. After such a packet is retired, the parser parks in `S_IDLE` until the host loads the write pointer again.

Top module: `cmd_ring_parser`

## Requirements
- R1: After reset the read pointer and the write pointer both equal `RING_BASE`, `ring_empty` is 1, `pkt_valid` is 0 and `hdr_error` is 0.
- R2: A header's kind is taken from bits 31:30. The value 2'b11 is a full packet, 2'b10 is a filler, and 2'b00 or 2'b01 is illegal.
- R3: While `pkt_valid` is 1, the outputs describe the packet whose header sits at the read pointer:
  - `pkt_opcode` is header bits 15:8.
  - `pkt_len` is header bits 29:16 plus 2.
  - `pkt_header` is the header word.
  - `pkt_payload` is the ring word at read pointer plus 1.
- R4: A filler word moves the read pointer forward by exactly one and never raises `pkt_valid`.
- R5: Before a header is fetched, a read pointer at or above `RING_BASE+RING_SIZE` is set back to `RING_BASE`. This takes one cycle in `S_IDLE`.
- R6: Fetching starts only while the read and write pointers differ. `ring_empty` is 1 exactly when they are equal.
- R7: While `pkt_valid` is 1 and `pkt_ready` is 0, the offer stays up, its fields do not change and the read pointer does not move.
- R8: In the cycle after a packet is accepted, the read pointer equals its old value plus `pkt_len`.
- R9: After a packet with opcode `IND_OPCODE` is accepted, no further header is fetched until `wp_load` is next asserted. A `wp_load` in the same cycle as that acceptance cancels the park.
- R10: An illegal header raises `hdr_error`. The flag stays set until reset, and from then on no packet is offered and the read pointer stays still.
- R11: The header is read at the clock edge that enters `S_RD_HDR`, which is the edge after `S_IDLE` sees a non-empty ring. `pkt_valid` rises three edges after that `S_IDLE` cycle. A ring write in the same cycle as a fetch returns the old word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_we | input | 1 | Host write enable for the ring memory |
| ring_waddr | input | AW | Host write address |
| ring_wdata | input | 32 | Host write data |
| wp_load | input | 1 | Load the write pointer; also clears a park |
| wp_value | input | PTR_W | New write pointer value |
| pkt_valid | output | 1 | A full packet is being offered |
| pkt_ready | input | 1 | Handler accepts the offered packet |
| pkt_opcode | output | 8 | Opcode of the offered packet |
| pkt_len | output | 15 | Packet length in words, header included |
| pkt_header | output | 32 | Raw header word |
| pkt_payload | output | 32 | Ring word following the header |
| rd_ptr | output | PTR_W | Current read pointer |
| ring_empty | output | 1 | Read pointer equals write pointer |
| hdr_error | output | 1 | Sticky illegal-header flag |

## Verification
Two of this block's functions can land in the same cycle: the retiring of a buffer-switch packet, which would park the parser, and a host write-pointer load, which releases a park.

The bench provokes the overlap directly. It holds `pkt_ready` low until the buffer-switch packet is on offer, then raises `pkt_ready` and pulses `wp_load` on the same edge. It judges the result by watching the parser go on to fetch the next packet, where a wrong priority would leave it parked.

A behavioural cycle model runs alongside the design and covers a second overlap: a ring write in the cycle a header is fetched. Stalls, fillers and wrap-around are compared against that model on every clock.

// File: rtl/cmd_ring_pkg.sv
package cmd_ring_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_HDR,
        S_RD_PAY,
        S_OFFER,
        S_ERROR
    } parse_state_t;

    typedef enum logic [1:0] {
        HK_PKT,
        HK_FILL,
        HK_BAD
    } hdr_kind_t;

    localparam int WORD_W = 32;
    localparam int OPC_W  = 8;
    localparam int LEN_W  = 15;
endpackage

// File: rtl/crp_ring_mem.sv
module crp_ring_mem #(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic                           clk,
    input  logic                           we,
    input  logic [AW-1:0]                  waddr,
    input  logic [cmd_ring_pkg::WORD_W-1:0] wdata,
    input  logic [AW-1:0]                  raddr,
    output logic [cmd_ring_pkg::WORD_W-1:0] rdata
);
    logic [cmd_ring_pkg::WORD_W-1:0] store [DEPTH];

    // Synchronous read; a write to the same word in the same cycle returns the old word.
    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
        rdata <= store[raddr];
    end
endmodule

// File: rtl/crp_hdr_decode.sv
module crp_hdr_decode
    import cmd_ring_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output hdr_kind_t         kind,
    output logic [OPC_W-1:0]  opcode,
    output logic [LEN_W-1:0]  len
);
    always_comb begin
        unique case (word[31:30])
            2'b11:   kind = HK_PKT;
            2'b10:   kind = HK_FILL;
            default: kind = HK_BAD;
        endcase
        opcode = word[15:8];
        len    = {1'b0, word[29:16]} + LEN_W'(2);
    end
endmodule

// File: rtl/cmd_ring_parser.sv
module cmd_ring_parser
    import cmd_ring_pkg::*;
#(
    parameter int         DEPTH      = 64,
    parameter int         AW         = $clog2(DEPTH),
    parameter int         RING_BASE  = 8,
    parameter int         RING_SIZE  = 48,
    parameter int         PTR_W      = 16,
    parameter logic [7:0] IND_OPCODE = 8'h32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ring_we,
    input  logic [AW-1:0]     ring_waddr,
    input  logic [31:0]       ring_wdata,
    input  logic              wp_load,
    input  logic [PTR_W-1:0]  wp_value,
    output logic              pkt_valid,
    input  logic              pkt_ready,
    output logic [7:0]        pkt_opcode,
    output logic [14:0]       pkt_len,
    output logic [31:0]       pkt_header,
    output logic [31:0]       pkt_payload,
    output logic [PTR_W-1:0]  rd_ptr,
    output logic              ring_empty,
    output logic              hdr_error
);
    localparam logic [PTR_W-1:0] BASE_P  = PTR_W'(RING_BASE);
    localparam logic [PTR_W-1:0] LIMIT_P = PTR_W'(RING_BASE + RING_SIZE);

    parse_state_t      state_q, state_d;
    logic [PTR_W-1:0]  rptr_q, rptr_d, wptr_q, rptr_p1;
    logic [WORD_W-1:0] hdr_q, hdr_d, pay_q, pay_d, rd_q;
    logic [OPC_W-1:0]  op_q, op_d, dec_op;
    logic [LEN_W-1:0]  len_q, len_d, dec_len;
    logic              hold_q, hold_d, set_hold;
    logic [AW-1:0]     rd_addr;
    hdr_kind_t         kind;

    assign rptr_p1 = rptr_q + PTR_W'(1);

    always_comb begin
        rd_addr = (state_q == S_IDLE) ? rptr_q[AW-1:0] : rptr_p1[AW-1:0];
    end

    crp_ring_mem #(.DEPTH(DEPTH), .AW(AW)) u_mem (
        .clk   (clk),
        .we    (ring_we),
        .waddr (ring_waddr),
        .wdata (ring_wdata),
        .raddr (rd_addr),
        .rdata (rd_q)
    );

    crp_hdr_decode u_dec (
        .word   (rd_q),
        .kind   (kind),
        .opcode (dec_op),
        .len    (dec_len)
    );

    // Next-state and datapath selection.
    always_comb begin
        state_d  = state_q;
        rptr_d   = rptr_q;
        hdr_d    = hdr_q;
        pay_d    = pay_q;
        op_d     = op_q;
        len_d    = len_q;
        set_hold = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (rptr_q >= LIMIT_P) begin
                    rptr_d = BASE_P;
                end else if (rptr_q != wptr_q && !hold_q) begin
                    state_d = S_RD_HDR;
                end
            end
            S_RD_HDR: begin
                unique case (kind)
                    HK_PKT: begin
                        hdr_d   = rd_q;
                        op_d    = dec_op;
                        len_d   = dec_len;
                        state_d = S_RD_PAY;
                    end
                    HK_FILL: begin
                        rptr_d  = rptr_p1;
                        state_d = S_IDLE;
                    end
                    default: state_d = S_ERROR;
                endcase
            end
            S_RD_PAY: begin
                pay_d   = rd_q;
                state_d = S_OFFER;
            end
            S_OFFER: begin
                if (pkt_ready) begin
                    rptr_d   = rptr_q + PTR_W'(len_q);
                    set_hold = (op_q == IND_OPCODE);
                    state_d  = S_IDLE;
                end
            end
            S_ERROR: state_d = S_ERROR;
        endcase
    end

    // A pointer load takes priority over a park request in the same cycle.
    assign hold_d = wp_load ? 1'b0 : (set_hold ? 1'b1 : hold_q);

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            rptr_q  <= BASE_P;
            wptr_q  <= BASE_P;
            hdr_q   <= '0;
            pay_q   <= '0;
            op_q    <= '0;
            len_q   <= '0;
            hold_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            rptr_q  <= rptr_d;
            hdr_q   <= hdr_d;
            pay_q   <= pay_d;
            op_q    <= op_d;
            len_q   <= len_d;
            hold_q  <= hold_d;
            if (wp_load) begin
                wptr_q <= wp_value;
            end
        end
    end

    // Outputs.
    always_comb begin
        pkt_valid   = (state_q == S_OFFER);
        pkt_opcode  = op_q;
        pkt_len     = len_q;
        pkt_header  = hdr_q;
        pkt_payload = pay_q;
        rd_ptr      = rptr_q;
        ring_empty  = (rptr_q == wptr_q);
        hdr_error   = (state_q == S_ERROR);
    end

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && !pkt_ready) |=> (pkt_valid && $stable(rd_ptr) && $stable(pkt_header)));

    // R8
    advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && pkt_ready) |=> (rd_ptr == $past(rd_ptr) + PTR_W'($past(pkt_len))));

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_error |=> (hdr_error && $stable(rd_ptr)));

    // R5
    hdr_in_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RD_HDR) |-> (rptr_q >= BASE_P && rptr_q < LIMIT_P));

    // R4
    filler_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RD_HDR && rd_q[31:30] == 2'b10) |=> (rptr_q == $past(rptr_q) + PTR_W'(1) && !pkt_valid));

    // R9
    park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q && state_q == S_IDLE) |=> (state_q == S_IDLE));
endmodule

// File: tb/sim_cmd_ring_parser.sv
module sim_cmd_ring_parser;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 64;
    localparam int AW = 6;
    localparam int BASE = 8;
    localparam int SIZE = 48;
    localparam int LIM = BASE + SIZE;
    localparam int PTR_W = 16;
    localparam logic [7:0] IND = 8'h32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ring_we = 1'b0;
    logic [AW-1:0] ring_waddr = '0;
    logic [31:0] ring_wdata = '0;
    logic wp_load = 1'b0;
    logic [PTR_W-1:0] wp_value = '0;
    logic pkt_ready = 1'b0;
    logic pkt_valid, ring_empty, hdr_error;
    logic [7:0] pkt_opcode;
    logic [14:0] pkt_len;
    logic [31:0] pkt_header, pkt_payload;
    logic [PTR_W-1:0] rd_ptr;

    int checks = 0;
    int fails = 0;
    bit cmp_on = 1'b0;

    // behavioural model state
    logic [31:0] bm [DEPTH];
    int m_rp, m_wp, m_ph;
    bit m_hold;
    logic [31:0] m_hdr, m_pay;

    cmd_ring_parser #(.DEPTH(DEPTH), .AW(AW), .RING_BASE(BASE), .RING_SIZE(SIZE),
                      .PTR_W(PTR_W), .IND_OPCODE(IND)) u0 (
        .clk(clk), .rst_n(rst_n), .ring_we(ring_we), .ring_waddr(ring_waddr),
        .ring_wdata(ring_wdata), .wp_load(wp_load), .wp_value(wp_value),
        .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_opcode(pkt_opcode),
        .pkt_len(pkt_len), .pkt_header(pkt_header), .pkt_payload(pkt_payload),
        .rd_ptr(rd_ptr), .ring_empty(ring_empty), .hdr_error(hdr_error)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] mk(input int t, input int cnt, input int op);
        return {t[1:0], cnt[13:0], op[7:0], 8'h00};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Cycle model (phases: 0 wait, 1 header, 2 payload, 3 offer, 4 fault)
    always @(posedge clk) begin
        if (!rst_n) begin
            m_rp = BASE; m_wp = BASE; m_ph = 0; m_hold = 1'b0;
        end else begin
            case (m_ph)
                0: begin
                    if (m_rp >= LIM) m_rp = BASE;
                    else if (m_rp != m_wp && !m_hold) begin
                        m_hdr = bm[m_rp % DEPTH]; m_ph = 1;
                    end
                end
                1: begin
                    if (m_hdr[31:30] == 2'b11) begin m_pay = bm[(m_rp + 1) % DEPTH]; m_ph = 2; end
                    else if (m_hdr[31:30] == 2'b10) begin m_rp = m_rp + 1; m_ph = 0; end
                    else m_ph = 4;
                end
                2: m_ph = 3;
                3: if (pkt_ready) begin
                    m_rp = m_rp + int'(m_hdr[29:16]) + 2;
                    if (m_hdr[15:8] == IND) m_hold = 1'b1;
                    m_ph = 0;
                end
                default: ;
            endcase
            if (wp_load) begin m_wp = int'(wp_value); m_hold = 1'b0; end
            if (ring_we) bm[ring_waddr] = ring_wdata;
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (cmp_on) begin
            chk(rd_ptr == PTR_W'(m_rp), "R8 rd_ptr", 32'(rd_ptr), 32'(m_rp));
            chk(pkt_valid == (m_ph == 3), "R6 pkt_valid", 32'(pkt_valid), 32'(m_ph == 3));
            chk(ring_empty == (m_rp == m_wp), "R6 ring_empty", 32'(ring_empty), 32'(m_rp == m_wp));
            chk(hdr_error == (m_ph == 4), "R10 hdr_error", 32'(hdr_error), 32'(m_ph == 4));
            if (m_ph == 3) begin
                chk(pkt_opcode == m_hdr[15:8], "R3 opcode", 32'(pkt_opcode), 32'(m_hdr[15:8]));
                chk(pkt_len == 15'(m_hdr[29:16]) + 15'd2, "R3 len", 32'(pkt_len), 32'(m_hdr[29:16]) + 2);
                chk(pkt_header === m_hdr, "R3 header", pkt_header, m_hdr);
                chk(pkt_payload === m_pay, "R3 payload", pkt_payload, m_pay);
            end
        end
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R6 watchdog expired");
        summary();
    end

    task automatic wr(input int a, input logic [31:0] d);
        ring_we = 1'b1; ring_waddr = AW'(a); ring_wdata = d;
        @(negedge clk);
        ring_we = 1'b0;
    endtask

    task automatic ldwp(input int v);
        wp_load = 1'b1; wp_value = PTR_W'(v);
        @(negedge clk);
        wp_load = 1'b0;
    endtask

    task automatic gap(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        gap(1);
        // R1 reset state
        chk(rd_ptr == 16'(BASE), "R1 rd_ptr", 32'(rd_ptr), BASE);
        chk(ring_empty && !pkt_valid && !hdr_error, "R1 flags",
            {29'd0, ring_empty, pkt_valid, hdr_error}, 32'h4);
        @(negedge clk);

        // Packets, filler and stall (R2 R3 R4 R7)
        wr(8, mk(3, 1, 8'h10)); wr(9, 32'hAAAA0001); wr(10, 32'h0000BEEF);
        wr(11, 32'h8000_0000);
        wr(12, mk(3, 0, 8'h21)); wr(13, 32'hBBBB0002);
        wr(14, mk(3, 2, 8'h22)); wr(15, 32'hCCCC0003); wr(16, 32'h1); wr(17, 32'h2);
        pkt_ready = 1'b0;
        ldwp(18);
        gap(10);
        chk(pkt_valid && rd_ptr == 16'd8, "R7 stalled offer", 32'(rd_ptr), 8);
        chk(pkt_payload == 32'hAAAA0001, "R3 first payload", pkt_payload, 32'hAAAA0001);
        pkt_ready = 1'b1;
        gap(30);
        chk(rd_ptr == 16'd18 && ring_empty, "R4 after filler and packets", 32'(rd_ptr), 18);

        // Wrap (R5)
        for (int i = 18; i < 50; i++) wr(i, 32'h8000_0000 | i);
        wr(50, mk(3, 4, 8'h40)); wr(51, 32'hDDDD0004);
        wr(8, mk(3, 0, 8'h41));
        ldwp(10);
        gap(120);
        chk(rd_ptr == 16'd10 && ring_empty, "R5 wrapped to base", 32'(rd_ptr), 10);

        // Buffer switch park (R9)
        wr(10, mk(3, 1, int'(IND))); wr(11, 32'hEEEE0005); wr(12, 32'h0);
        wr(13, mk(3, 0, 8'h11)); wr(14, 32'hFFFF0006);
        ldwp(15);
        gap(30);
        chk(rd_ptr == 16'd13 && !ring_empty && !pkt_valid, "R9 parked", 32'(rd_ptr), 13);
        @(negedge clk);
        ldwp(15);
        gap(20);
        chk(rd_ptr == 16'd15 && ring_empty, "R9 resumed", 32'(rd_ptr), 15);

        // Park request and pointer load in one cycle (R9)
        @(negedge clk);
        wr(15, mk(3, 0, int'(IND))); wr(16, 32'h12340007);
        wr(17, mk(3, 0, 8'h12)); wr(18, 32'h12340008);
        pkt_ready = 1'b0;
        ldwp(19);
        while (!pkt_valid) @(negedge clk);
        pkt_ready = 1'b1; wp_load = 1'b1; wp_value = 16'd19;
        @(negedge clk);
        wp_load = 1'b0;
        gap(15);
        chk(rd_ptr == 16'd19 && ring_empty, "R9 load wins over park", 32'(rd_ptr), 19);

        // Illegal type 2'b01 (R10, R2)
        @(negedge clk);
        wr(19, 32'h4000_1234); wr(20, mk(3, 0, 8'h13)); wr(21, 32'h0);
        ldwp(22);
        gap(20);
        chk(hdr_error && !pkt_valid && rd_ptr == 16'd19, "R10 sticky error", 32'(rd_ptr), 19);

        // Illegal type 2'b00 after a fresh reset (R2, R11 fetch timing via model)
        @(negedge clk);
        rst_n = 1'b0;
        gap(2);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!hdr_error && rd_ptr == 16'(BASE), "R1 reset clears error", 32'(hdr_error), 0);
        wr(8, 32'h0000_0000);
        ldwp(9);
        gap(10);
        chk(hdr_error && rd_ptr == 16'd8, "R2 type zero is illegal", 32'(hdr_error), 1);
        cmp_on = 1'b0;
        summary();
    end
endmodule